// File: doc/BRIEF.md
# I/O Queue Create/Delete Command Validator

This block sits in the admin path of a storage controller and handles the four commands that create and delete I/O submission queues (SQs) and I/O completion queues (CQs). A command arrives as an opcode, two 32-bit command dwords and a 64-bit queue base address. The block checks each field in a fixed order and returns a completion status made of a status code type and a status code. When every check passes, it also updates its per-queue register table.

The table holds, for each SQ, an active flag, base address, entry count, linked CQ and priority. For each CQ it holds an active flag, base address, entry count, interrupt enable and interrupt vector. Downstream fetch and doorbell logic reads the table through two combinational lookup ports, one for SQs and one for CQs.

A command is accepted on any cycle in which `cmd_valid` is high. Its status appears one cycle later with a one-cycle `sts_valid` strobe. Any table change becomes visible on the lookup ports in that same cycle. The numbers of SQs and CQs, the maximum entry count and the highest legal interrupt vector are parameters.

Top module: `ioq_admin_validator`

## Requirements
- R1: `cmd_ready` is always high. Each cycle with `cmd_valid` high produces `sts_valid` high in the next cycle only. After reset `sts_valid` is low and every queue is inactive.
- R2: The queue ID is `cmd_dw10[15:0]`. An ID of 0, or an ID above NUM_SQ (for SQ commands) or NUM_CQ (for CQ commands), returns type 1 code 0x01 (bad queue ID).
- R3: A create aimed at an active queue returns type 1 code 0x01. So does a delete aimed at an inactive queue.
- R4: The entry count is `cmd_dw10[31:16]` plus one. On a create, a count below 2 or above MAX_ENTRIES returns type 1 code 0x02 (bad size). This check runs after the queue ID checks.
- R5: On an SQ create, the linked CQ is `cmd_dw11[31:16]` and is checked after the size. A link of 0 or above NUM_CQ returns type 1 code 0x01. A link to an inactive CQ returns type 1 code 0x00 (CQ not usable).
- R6: On either create, a clear contiguous flag `cmd_dw11[0]` returns type 0 code 0x02 (bad field). This check comes before every other check.
- R7: On a CQ create, an interrupt vector `cmd_dw11[31:16]` above MAX_VECTOR returns type 1 code 0x08. This check runs after the queue ID checks and before the size check.
- R8: Deleting an active CQ while any active SQ is linked to it returns type 1 code 0x0C (queue in use).
- R9: A failing command leaves the table unchanged. A command that passes every check returns type 0 code 0x00 and changes exactly one queue's active flag.
- R10: A successful SQ create stores the base, the entry count, the link and the priority `cmd_dw11[2:1]`. A successful CQ create stores the base, the entry count, the interrupt enable `cmd_dw11[1]` and the vector. A successful SQ delete clears the SQ's active flag and sets its link to 0. The lookup ports show these values in the cycle the status appears, and show an inactive queue for any out-of-range ID.
- R11: The opcodes are 0x00 delete SQ, 0x01 create SQ, 0x04 delete CQ and 0x05 create CQ. Any other opcode returns type 0 code 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_opcode | input | 8 | Admin opcode |
| cmd_dw10 | input | 32 | Queue ID [15:0], zero-based size [31:16] |
| cmd_dw11 | input | 32 | Contiguous flag [0], priority or interrupt enable [2:1], link or vector [31:16] |
| cmd_base | input | 64 | Queue base address |
| sts_valid | output | 1 | Status strobe, one cycle |
| sts_type | output | 3 | Status code type |
| sts_code | output | 8 | Status code |
| lk_sq_id | input | 16 | SQ lookup ID |
| lk_sq_active | output | 1 | SQ is active |
| lk_sq_base | output | 64 | SQ base address |
| lk_sq_entries | output | 17 | SQ entry count |
| lk_sq_cqid | output | 16 | SQ linked CQ |
| lk_sq_prio | output | 2 | SQ priority |
| lk_cq_id | input | 16 | CQ lookup ID |
| lk_cq_active | output | 1 | CQ is active |
| lk_cq_base | output | 64 | CQ base address |
| lk_cq_entries | output | 17 | CQ entry count |
| lk_cq_ien | output | 1 | CQ interrupt enable |
| lk_cq_vector | output | 16 | CQ interrupt vector |

## Verification
The bench runs a long pseudo-random mix of commands over queue IDs 0 to 5, sizes at both edges of the legal range, and links and vectors around their limits. It also varies the contiguous flag and includes unknown opcodes. A design that checked the fields in the wrong order would return, for example, a size error where a vector or link error is expected, or a bad-field status would lose its precedence. A design that ignored the link scan would delete a CQ that an SQ still uses. A design that updated the table on failure, or that did not clear the link on SQ delete, would later accept a create it should reject, or refuse a CQ delete it should allow. The bench catches both through the status codes and the lookup ports.

// File: rtl/ioq_admin_validator.sv
module ioq_admin_validator #(
  parameter int NUM_SQ      = 4,
  parameter int NUM_CQ      = 4,
  parameter int MAX_ENTRIES = 64,
  parameter int MAX_VECTOR  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_opcode,
  input  logic [31:0] cmd_dw10,
  input  logic [31:0] cmd_dw11,
  input  logic [63:0] cmd_base,
  output logic        sts_valid,
  output logic [2:0]  sts_type,
  output logic [7:0]  sts_code,
  input  logic [15:0] lk_sq_id,
  output logic        lk_sq_active,
  output logic [63:0] lk_sq_base,
  output logic [16:0] lk_sq_entries,
  output logic [15:0] lk_sq_cqid,
  output logic [1:0]  lk_sq_prio,
  input  logic [15:0] lk_cq_id,
  output logic        lk_cq_active,
  output logic [63:0] lk_cq_base,
  output logic [16:0] lk_cq_entries,
  output logic        lk_cq_ien,
  output logic [15:0] lk_cq_vector
);
  localparam logic [7:0]  OP_DEL_SQ = 8'h00, OP_NEW_SQ = 8'h01;
  localparam logic [7:0]  OP_DEL_CQ = 8'h04, OP_NEW_CQ = 8'h05;
  localparam logic [2:0]  SCT_GEN = 3'd0, SCT_CMD = 3'd1;
  localparam logic [7:0]  SC_OK = 8'h00, SC_BAD_OP = 8'h01, SC_BAD_FIELD = 8'h02;
  localparam logic [7:0]  SC_CQ_UNUSABLE = 8'h00, SC_BAD_QID = 8'h01, SC_BAD_SIZE = 8'h02;
  localparam logic [7:0]  SC_BAD_VEC = 8'h08, SC_IN_USE = 8'h0C;
  localparam logic [16:0] ENT_MAX = 17'(MAX_ENTRIES);
  localparam logic [15:0] VEC_MAX = 16'(MAX_VECTOR);

  logic [NUM_SQ-1:0]       sq_act;
  logic [NUM_SQ-1:0][15:0] sq_cqid;
  logic [63:0]             sq_base [NUM_SQ];
  logic [16:0]             sq_ent  [NUM_SQ];
  logic [1:0]              sq_prio [NUM_SQ];
  logic [NUM_CQ-1:0]       cq_act;
  logic [63:0]             cq_base [NUM_CQ];
  logic [16:0]             cq_ent  [NUM_CQ];
  logic                    cq_ien  [NUM_CQ];
  logic [15:0]             cq_vec  [NUM_CQ];

  wire [15:0] qid     = cmd_dw10[15:0];
  wire [16:0] entries = {1'b0, cmd_dw10[31:16]} + 17'd1;
  wire [15:0] link    = cmd_dw11[31:16];
  wire        contig  = cmd_dw11[0];
  wire        fire    = cmd_valid & cmd_ready;
  wire        unused_dw11 = &{1'b0, cmd_dw11[15:3]};

  logic [NUM_SQ-1:0] sq_sel, sq_linked;
  logic [NUM_CQ-1:0] cq_sel, link_sel;

  for (genvar i = 0; i < NUM_SQ; i++) begin : g_sq_dec
    assign sq_sel[i]    = (qid == 16'(i + 1));
    assign sq_linked[i] = sq_act[i] && (sq_cqid[i] == qid);
  end
  for (genvar j = 0; j < NUM_CQ; j++) begin : g_cq_dec
    assign cq_sel[j]   = (qid == 16'(j + 1));
    assign link_sel[j] = (link == 16'(j + 1));
  end

  wire sq_in    = |sq_sel;
  wire sq_hit   = |(sq_sel & sq_act);
  wire cq_in    = |cq_sel;
  wire cq_hit   = |(cq_sel & cq_act);
  wire link_in  = |link_sel;
  wire link_act = |(link_sel & cq_act);
  wire cq_busy  = |sq_linked;
  wire size_bad = (entries < 17'd2) || (entries > ENT_MAX);
  wire vec_bad  = link > VEC_MAX;

  logic       dec_ok;
  logic [2:0] dec_type;
  logic [7:0] dec_code;

  always_comb begin
    dec_ok   = 1'b0;
    dec_type = SCT_CMD;
    dec_code = SC_OK;
    case (cmd_opcode)
      OP_DEL_SQ:
        if (!sq_hit) dec_code = SC_BAD_QID;
        else dec_ok = 1'b1;
      OP_NEW_SQ:
        if (!contig) begin dec_type = SCT_GEN; dec_code = SC_BAD_FIELD; end
        else if (!sq_in || sq_hit) dec_code = SC_BAD_QID;
        else if (size_bad)         dec_code = SC_BAD_SIZE;
        else if (!link_in)         dec_code = SC_BAD_QID;
        else if (!link_act)        dec_code = SC_CQ_UNUSABLE;
        else dec_ok = 1'b1;
      OP_DEL_CQ:
        if (!cq_hit)      dec_code = SC_BAD_QID;
        else if (cq_busy) dec_code = SC_IN_USE;
        else dec_ok = 1'b1;
      OP_NEW_CQ:
        if (!contig) begin dec_type = SCT_GEN; dec_code = SC_BAD_FIELD; end
        else if (!cq_in || cq_hit) dec_code = SC_BAD_QID;
        else if (vec_bad)          dec_code = SC_BAD_VEC;
        else if (size_bad)         dec_code = SC_BAD_SIZE;
        else dec_ok = 1'b1;
      default: begin dec_type = SCT_GEN; dec_code = SC_BAD_OP; end
    endcase
    if (dec_ok) begin dec_type = SCT_GEN; dec_code = SC_OK; end
  end

  assign cmd_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_type  <= '0;
      sts_code  <= '0;
    end else begin
      sts_valid <= fire;
      sts_type  <= fire ? dec_type : '0;
      sts_code  <= fire ? dec_code : '0;
    end

  wire do_sq = fire && dec_ok && (cmd_opcode == OP_DEL_SQ || cmd_opcode == OP_NEW_SQ);
  wire do_cq = fire && dec_ok && (cmd_opcode == OP_DEL_CQ || cmd_opcode == OP_NEW_CQ);

  for (genvar i = 0; i < NUM_SQ; i++) begin : g_sq_tab
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sq_act[i]  <= 1'b0;
        sq_cqid[i] <= '0;
        sq_base[i] <= '0;
        sq_ent[i]  <= '0;
        sq_prio[i] <= '0;
      end else if (do_sq && sq_sel[i]) begin
        sq_act[i]  <= cmd_opcode == OP_NEW_SQ;
        sq_cqid[i] <= (cmd_opcode == OP_NEW_SQ) ? link : 16'd0;
        if (cmd_opcode == OP_NEW_SQ) begin
          sq_base[i] <= cmd_base;
          sq_ent[i]  <= entries;
          sq_prio[i] <= cmd_dw11[2:1];
        end
      end
  end

  for (genvar j = 0; j < NUM_CQ; j++) begin : g_cq_tab
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cq_act[j]  <= 1'b0;
        cq_base[j] <= '0;
        cq_ent[j]  <= '0;
        cq_ien[j]  <= 1'b0;
        cq_vec[j]  <= '0;
      end else if (do_cq && cq_sel[j]) begin
        cq_act[j] <= cmd_opcode == OP_NEW_CQ;
        if (cmd_opcode == OP_NEW_CQ) begin
          cq_base[j] <= cmd_base;
          cq_ent[j]  <= entries;
          cq_ien[j]  <= cmd_dw11[1];
          cq_vec[j]  <= link;
        end
      end
  end

  always_comb begin
    lk_sq_active = 1'b0; lk_sq_base = '0; lk_sq_entries = '0; lk_sq_cqid = '0; lk_sq_prio = '0;
    for (int i = 0; i < NUM_SQ; i++)
      if (lk_sq_id == 16'(i + 1)) begin
        lk_sq_active  = sq_act[i];
        lk_sq_base    = sq_base[i];
        lk_sq_entries = sq_ent[i];
        lk_sq_cqid    = sq_cqid[i];
        lk_sq_prio    = sq_prio[i];
      end
  end

  always_comb begin
    lk_cq_active = 1'b0; lk_cq_base = '0; lk_cq_entries = '0; lk_cq_ien = 1'b0; lk_cq_vector = '0;
    for (int j = 0; j < NUM_CQ; j++)
      if (lk_cq_id == 16'(j + 1)) begin
        lk_cq_active  = cq_act[j];
        lk_cq_base    = cq_base[j];
        lk_cq_entries = cq_ent[j];
        lk_cq_ien     = cq_ien[j];
        lk_cq_vector  = cq_vec[j];
      end
  end
endmodule

// File: rtl/ioq_admin_validator_chk.sv
module ioq_admin_validator_chk #(
  parameter int NUM_SQ = 4,
  parameter int NUM_CQ = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [7:0]              cmd_opcode,
  input logic                    sts_valid,
  input logic [2:0]              sts_type,
  input logic [7:0]              sts_code,
  input logic [NUM_SQ-1:0]       sq_act,
  input logic [NUM_CQ-1:0]       cq_act,
  input logic [NUM_SQ-1:0][15:0] sq_cqid
);
  wire known_op = cmd_opcode == 8'h00 || cmd_opcode == 8'h01 ||
                  cmd_opcode == 8'h04 || cmd_opcode == 8'h05;
  wire sts_ok   = sts_type == 3'd0 && sts_code == 8'h00;

  AST_STS_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> sts_valid); // R1
  AST_STS_ONLY_FOR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !sts_valid); // R1
  AST_UNKNOWN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !known_op) |=> (sts_type == 3'd0 && sts_code == 8'h01)); // R11
  AST_FAIL_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_ok) |-> (sq_act == $past(sq_act) && cq_act == $past(cq_act)
                                && sq_cqid == $past(sq_cqid))); // R9
  AST_SUCCESS_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && sts_ok) |-> ($countones(sq_act ^ $past(sq_act)) +
                               $countones(cq_act ^ $past(cq_act)) == 1)); // R9

  for (genvar i = 0; i < NUM_SQ; i++) begin : g_link
    AST_LINK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sq_act[i] |-> (sq_cqid[i] != 16'd0 && sq_cqid[i] <= 16'(NUM_CQ))); // R5
    AST_IDLE_SQ_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_act[i] |-> sq_cqid[i] == 16'd0); // R10
    for (genvar j = 0; j < NUM_CQ; j++) begin : g_cq
      AST_LINKED_CQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_act[i] && sq_cqid[i] == 16'(j + 1)) |-> cq_act[j]); // R8
    end
  end
endmodule

bind ioq_admin_validator ioq_admin_validator_chk #(.NUM_SQ(NUM_SQ), .NUM_CQ(NUM_CQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
  .sts_valid(sts_valid), .sts_type(sts_type), .sts_code(sts_code),
  .sq_act(sq_act), .cq_act(cq_act), .sq_cqid(sq_cqid));

// File: tb/test_ioq_admin_validator.sv
module test_ioq_admin_validator;
  localparam int NSQ = 4, NCQ = 4, MAXE = 64, MAXV = 5;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [7:0] cmd_opcode = 0;
  logic [31:0] cmd_dw10 = 0, cmd_dw11 = 0;
  logic [63:0] cmd_base = 0;
  logic sts_valid;
  logic [2:0] sts_type;
  logic [7:0] sts_code;
  logic [15:0] lk_sq_id = 0, lk_cq_id = 0;
  logic lk_sq_active, lk_cq_active, lk_cq_ien;
  logic [63:0] lk_sq_base, lk_cq_base;
  logic [16:0] lk_sq_entries, lk_cq_entries;
  logic [15:0] lk_sq_cqid, lk_cq_vector;
  logic [1:0] lk_sq_prio;

  always #5 clk = ~clk;

  ioq_admin_validator #(.NUM_SQ(NSQ), .NUM_CQ(NCQ), .MAX_ENTRIES(MAXE), .MAX_VECTOR(MAXV))
  i_ioq_admin_validator (.*);

  int n_chk = 0, n_fail = 0;
  bit m_sq_act [1:NSQ];
  int m_sq_cq [1:NSQ];
  logic [63:0] m_sq_base [1:NSQ];
  int m_sq_ent [1:NSQ];
  int m_sq_prio [1:NSQ];
  bit m_cq_act [1:NCQ];
  logic [63:0] m_cq_base [1:NCQ];
  int m_cq_ent [1:NCQ];
  int m_cq_ien [1:NCQ];
  int m_cq_vec [1:NCQ];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic expect_sts(input logic [7:0] op, input logic [31:0] d10, input logic [31:0] d11,
                            output int t, output int c, output string tag);
    int q = d10[15:0], e = int'(d10[31:16]) + 1, l = d11[31:16];
    bit busy = 0;
    t = 1; c = 0; tag = "R9";
    case (op)
      8'h00: if (q == 0 || q > NSQ) begin c = 1; tag = "R2"; end
             else if (!m_sq_act[q]) begin c = 1; tag = "R3"; end
             else t = 0;
      8'h01: if (!d11[0]) begin t = 0; c = 2; tag = "R6"; end
             else if (q == 0 || q > NSQ) begin c = 1; tag = "R2"; end
             else if (m_sq_act[q]) begin c = 1; tag = "R3"; end
             else if (e < 2 || e > MAXE) begin c = 2; tag = "R4"; end
             else if (l == 0 || l > NCQ) begin c = 1; tag = "R5"; end
             else if (!m_cq_act[l]) begin c = 0; tag = "R5"; end
             else t = 0;
      8'h04: begin
               if (q >= 1 && q <= NCQ)
                 for (int s = 1; s <= NSQ; s++) if (m_sq_act[s] && m_sq_cq[s] == q) busy = 1;
               if (q == 0 || q > NCQ) begin c = 1; tag = "R2"; end
               else if (!m_cq_act[q]) begin c = 1; tag = "R3"; end
               else if (busy) begin c = 12; tag = "R8"; end
               else t = 0;
             end
      8'h05: if (!d11[0]) begin t = 0; c = 2; tag = "R6"; end
             else if (q == 0 || q > NCQ) begin c = 1; tag = "R2"; end
             else if (m_cq_act[q]) begin c = 1; tag = "R3"; end
             else if (l > MAXV) begin c = 8; tag = "R7"; end
             else if (e < 2 || e > MAXE) begin c = 2; tag = "R4"; end
             else t = 0;
      default: begin t = 0; c = 1; tag = "R11"; end
    endcase
  endtask

  task automatic check_tables();
    for (int id = 0; id <= 5; id++) begin
      lk_sq_id = 16'(id); lk_cq_id = 16'(id);
      #1;
      if (id >= 1 && id <= NSQ) begin
        chk("R10 sq active", 64'(lk_sq_active), 64'(m_sq_act[id]));
        chk("R10 sq link", 64'(lk_sq_cqid), m_sq_act[id] ? 64'(m_sq_cq[id]) : 64'd0);
        if (m_sq_act[id]) begin
          chk("R10 sq base", lk_sq_base, m_sq_base[id]);
          chk("R10 sq entries", 64'(lk_sq_entries), 64'(m_sq_ent[id]));
          chk("R10 sq prio", 64'(lk_sq_prio), 64'(m_sq_prio[id]));
        end
      end else chk("R10 sq out of range", 64'(lk_sq_active), 64'd0);
      if (id >= 1 && id <= NCQ) begin
        chk("R10 cq active", 64'(lk_cq_active), 64'(m_cq_act[id]));
        if (m_cq_act[id]) begin
          chk("R10 cq base", lk_cq_base, m_cq_base[id]);
          chk("R10 cq entries", 64'(lk_cq_entries), 64'(m_cq_ent[id]));
          chk("R10 cq ien", 64'(lk_cq_ien), 64'(m_cq_ien[id]));
          chk("R10 cq vector", 64'(lk_cq_vector), 64'(m_cq_vec[id]));
        end
      end else chk("R10 cq out of range", 64'(lk_cq_active), 64'd0);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [31:0] d10, input logic [31:0] d11,
                        input logic [63:0] base);
    int t, c, q;
    string tag;
    expect_sts(op, d10, d11, t, c, tag);
    @(negedge clk);
    cmd_valid = 1; cmd_opcode = op; cmd_dw10 = d10; cmd_dw11 = d11; cmd_base = base;
    chk("R1 ready", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    cmd_valid = 0;
    chk("R1 status strobe", 64'(sts_valid), 64'd1);
    chk({tag, " status type"}, 64'(sts_type), 64'(t));
    chk({tag, " status code"}, 64'(sts_code), 64'(c));
    q = d10[15:0];
    if (t == 0 && c == 0) begin
      case (op)
        8'h00: begin m_sq_act[q] = 0; m_sq_cq[q] = 0; end
        8'h01: begin m_sq_act[q] = 1; m_sq_cq[q] = d11[31:16]; m_sq_base[q] = base;
                     m_sq_ent[q] = int'(d10[31:16]) + 1; m_sq_prio[q] = d11[2:1]; end
        8'h04: m_cq_act[q] = 0;
        default: begin m_cq_act[q] = 1; m_cq_base[q] = base; m_cq_ent[q] = int'(d10[31:16]) + 1;
                       m_cq_ien[q] = d11[1]; m_cq_vec[q] = d11[31:16]; end
      endcase
    end
    check_tables();
    @(posedge clk); #1;
    chk("R1 strobe one cycle", 64'(sts_valid), 64'd0);
  endtask

  function automatic logic [31:0] dw10(input int q, input int size_field);
    return {16'(size_field), 16'(q)};
  endfunction

  function automatic logic [31:0] dw11(input int hi, input int mid, input bit pc);
    return {16'(hi), 13'd0, 2'(mid), pc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ops [10] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h00, 8'h01, 8'h04, 8'h05, 8'h02, 8'hFF};
    int sizes [8] = '{0, 1, 2, 62, 63, 64, 7, 30};
    for (int i = 1; i <= NSQ; i++) begin m_sq_act[i] = 0; m_sq_cq[i] = 0; end
    for (int i = 1; i <= NCQ; i++) m_cq_act[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset strobe", 64'(sts_valid), 64'd0);
    check_tables();
    rst_n = 1;

    do_cmd(8'h05, dw10(1, 15), dw11(2, 1, 0), 64'h1000);   // R6 no contiguous flag
    do_cmd(8'h05, dw10(0, 15), dw11(2, 1, 1), 64'h1000);   // R2 id zero
    do_cmd(8'h05, dw10(5, 15), dw11(2, 1, 1), 64'h1000);   // R2 above count
    do_cmd(8'h05, dw10(1, 0),  dw11(6, 1, 1), 64'h1000);   // R7 before R4
    do_cmd(8'h05, dw10(1, 0),  dw11(5, 1, 1), 64'h1000);   // R4 one entry
    do_cmd(8'h05, dw10(1, 64), dw11(5, 1, 1), 64'h1000);   // R4 above max
    do_cmd(8'h05, dw10(1, 63), dw11(5, 1, 1), 64'h1000);   // R10 success at max
    do_cmd(8'h05, dw10(1, 1),  dw11(0, 0, 1), 64'h2000);   // R3 already active
    do_cmd(8'h01, dw10(1, 0),  dw11(9, 3, 1), 64'h3000);   // R4 before R5
    do_cmd(8'h01, dw10(1, 1),  dw11(0, 3, 1), 64'h3000);   // R5 link zero
    do_cmd(8'h01, dw10(1, 1),  dw11(2, 3, 1), 64'h3000);   // R5 inactive CQ
    do_cmd(8'h01, dw10(1, 1),  dw11(1, 3, 1), 64'h3000);   // R10 success, two entries
    do_cmd(8'h04, dw10(1, 0),  32'd0,         64'h0);      // R8 linked
    do_cmd(8'h00, dw10(1, 0),  32'd0,         64'h0);      // R10 delete SQ
    do_cmd(8'h00, dw10(1, 0),  32'd0,         64'h0);      // R3 delete inactive
    do_cmd(8'h04, dw10(1, 0),  32'd0,         64'h0);      // R9 now allowed
    do_cmd(8'h07, dw10(1, 0),  32'd0,         64'h0);      // R11 unknown opcode

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a = nxt(), b = nxt();
      logic [63:0] base = {nxt(), nxt()};
      do_cmd(ops[a % 10], dw10(int'((a >> 4) % 6), sizes[(a >> 8) % 8]),
             dw11(int'((a >> 12) % 7), int'(b[1:0]), (b[4:2] != 3'd0)), base);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule